// File: doc/BRIEF.md
# Servo Pulse Position Decoder

This block decodes one channel of a hobby radio-control receiver. The receiver sends a pulse about fifty times a second, and the length of its high phase sets the commanded position. The block brings the asynchronous pulse into the clock domain and counts the high phase in clock cycles. It limits the count to the legal window, from 0.8 ms to 2.2 ms at the default 50 MHz clock, and rescales it to a centred signed 10-bit position. The window's lower end gives -512, its centre gives 0 and its upper end gives +511. A separate flag reports whether pulses are still arriving. A receiver with several channels uses one copy of the block per channel.

Each finished pulse yields one position word on a valid/ready output. The consumer may hold `pos_ready` low. The word then waits with `pos_valid` high. If another pulse finishes before the word is taken, the newer position replaces it, because only the latest stick position matters. Nothing else is queued. The signal-present flag is a plain level.

Top module: `rc_pulse_decoder`

## Requirements
- R1: After reset, `pos_valid` and `sig_present` are both 0.
- R2: The high time is the number of clock cycles the synchronised input stays high. A pulse is measured only after a low-to-high transition has been seen, so a level that is already high when reset is released produces no output when it falls.
- R3: A high time L in [MIN_CYC, MAX_CYC] gives the position q - 512, with q = floor(((L - MIN_CYC) * 1023 + floor(SPAN/2)) / SPAN) and SPAN = MAX_CYC - MIN_CYC. This is presented as a 10-bit two's-complement value, so MIN_CYC gives -512, MAX_CYC gives +511 and the centre of an even span gives 0.
- R4: A high time below MIN_CYC is treated as MIN_CYC, and one above MAX_CYC is treated as MAX_CYC, before scaling.
- R5: Once `pos_valid` is high, it stays high while `pos_ready` is low. A word is transferred on a clock edge where both signals are high.
- R6: If a new position is produced while an earlier word is still untaken, the new value replaces it, and only one word is delivered.
- R7: `sig_present` goes to 1 after a low-to-high transition of the input.
- R8: `sig_present` returns to 0 once LOSS_CYC clock cycles pass with no low-to-high transition.
- R9: Each measured pulse produces exactly one word. After a transfer, `pos_valid` drops unless a newer result arrives in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rc_in | input | 1 | Asynchronous pulse input from the receiver |
| pos_data | output | 10 | Signed position, two's complement |
| pos_valid | output | 1 | Position word available |
| pos_ready | input | 1 | Consumer accepts the word |
| sig_present | output | 1 | Pulses seen within the loss window |

## Verification
An error in the measure counter or the arming flag shows up at the ports as a wrong position, or as a word that is missing or extra. This is visible a scaler latency (about 30 cycles) after the pulse's falling edge. An error in the iterative scaler appears at the port as a value off by a small amount or a power of two, which the scoreboard catches on the next transfer. A gap counter that runs wrong moves the fall of `sig_present` away from the LOSS_CYC window. The bench probes that window just before and just after its limit.

// File: rtl/rcpw_pkg.sv
package rcpw_pkg;
  localparam int POS_W = 10;
  typedef logic [POS_W-1:0] pos_t;
endpackage

// File: rtl/rcpw_sync.sv
module rcpw_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic lvl,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] shreg;
  logic              prev;

  // Reset to ones: a line already high at reset is not a rising edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '1;
      prev  <= 1'b1;
    end else begin
      shreg <= {shreg[STAGES-2:0], async_in};
      prev  <= shreg[STAGES-1];
    end
  end

  assign lvl  = shreg[STAGES-1];
  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;
endmodule

// File: rtl/rcpw_meas.sv
module rcpw_meas #(
  parameter int MIN_CYC  = 40000,
  parameter int MAX_CYC  = 110000,
  parameter int LOSS_CYC = 5000000,
  localparam int CW = $clog2(MAX_CYC + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lvl,
  input  logic          rise,
  input  logic          fall,
  output logic          done,
  output logic [CW-1:0] len,
  output logic          present
);
  localparam int GW      = $clog2(LOSS_CYC + 1);
  localparam int CAP     = MAX_CYC + 1;
  localparam int LOSS_M1 = LOSS_CYC - 1;
  localparam logic [CW-1:0] MIN_T  = MIN_CYC[CW-1:0];
  localparam logic [CW-1:0] MAX_T  = MAX_CYC[CW-1:0];
  localparam logic [CW-1:0] CAP_T  = CAP[CW-1:0];
  localparam logic [GW-1:0] LOSS_T = LOSS_CYC[GW-1:0];
  localparam logic [GW-1:0] LM1_T  = LOSS_M1[GW-1:0];

  logic [CW-1:0] cnt;
  logic [GW-1:0] gap;
  logic          armed;
  logic [CW-1:0] clamped;

  always_comb begin
    if (cnt < MIN_T)      clamped = MIN_T;
    else if (cnt > MAX_T) clamped = MAX_T;
    else                  clamped = cnt;
  end

  // High-time counter, saturating one past the window.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      armed <= 1'b0;
      done  <= 1'b0;
      len   <= MIN_T;
    end else begin
      done <= 1'b0;
      if (rise) begin
        cnt   <= CW'(1);
        armed <= 1'b1;
      end else if (fall) begin
        armed <= 1'b0;
        if (armed) begin
          done <= 1'b1;
          len  <= clamped;
        end
      end else if (armed && lvl && cnt != CAP_T) begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  // Loss-of-signal window.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap     <= LOSS_T;
      present <= 1'b0;
    end else if (rise) begin
      gap     <= '0;
      present <= 1'b1;
    end else if (gap != LOSS_T) begin
      gap <= gap + GW'(1);
      if (gap == LM1_T) present <= 1'b0;
    end
  end
endmodule

// File: rtl/rcpw_scale.sv
module rcpw_scale
  import rcpw_pkg::*;
#(
  parameter int MIN_CYC = 40000,
  parameter int MAX_CYC = 110000,
  localparam int CW = $clog2(MAX_CYC + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] len,
  output logic          done,
  output pos_t          result
);
  localparam int SPAN = MAX_CYC - MIN_CYC;
  localparam int HALF = SPAN / 2;
  localparam int DW   = $clog2(SPAN + 1);
  localparam int NW   = POS_W + DW;
  localparam int SW   = $clog2(NW + 1);
  localparam logic [CW-1:0] MIN_T  = MIN_CYC[CW-1:0];
  localparam logic [DW:0]   SPAN_T = SPAN[DW:0];
  localparam logic [NW-1:0] HALF_T = HALF[NW-1:0];
  localparam logic [SW-1:0] NW_T   = NW[SW-1:0];

  logic [CW-1:0] off_full;
  logic [NW-1:0] off_n;
  logic [NW-1:0] num_init;
  logic [NW-1:0] num;
  logic [DW-1:0] rem;
  logic [DW:0]   trial;
  logic [DW:0]   diff;
  logic [SW-1:0] step;
  logic          busy;

  assign off_full = len - MIN_T;
  assign off_n    = {{(NW-DW){1'b0}}, off_full[DW-1:0]};
  assign num_init = (off_n << POS_W) - off_n + HALF_T;
  assign trial    = {rem, num[NW-1]};
  assign diff     = trial - SPAN_T;

  // Restoring division; the numerator register fills with quotient bits.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      num  <= '0;
      rem  <= '0;
      step <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        num  <= num_init;
        rem  <= '0;
        step <= NW_T;
        busy <= 1'b1;
      end else if (busy) begin
        if (trial >= SPAN_T) begin
          rem <= diff[DW-1:0];
          num <= {num[NW-2:0], 1'b1};
        end else begin
          rem <= trial[DW-1:0];
          num <= {num[NW-2:0], 1'b0};
        end
        step <= step - SW'(1);
        if (step == SW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  // Subtracting 512 from an unsigned 0..1023 flips the sign bit.
  assign result = {~num[POS_W-1], num[POS_W-2:0]};
endmodule

// File: rtl/rc_pulse_decoder.sv
module rc_pulse_decoder
  import rcpw_pkg::*;
#(
  parameter int MIN_CYC     = 40000,
  parameter int MAX_CYC     = 110000,
  parameter int LOSS_CYC    = 5000000,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rc_in,
  output logic [POS_W-1:0] pos_data,
  output logic             pos_valid,
  input  logic             pos_ready,
  output logic             sig_present
);
  localparam int CW = $clog2(MAX_CYC + 2);

  logic          lvl, rise_evt, fall_evt;
  logic          meas_done;
  logic [CW-1:0] meas_len;
  logic          scale_done;
  pos_t          scale_res;

  rcpw_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(rc_in),
    .lvl(lvl), .rise(rise_evt), .fall(fall_evt)
  );

  rcpw_meas #(.MIN_CYC(MIN_CYC), .MAX_CYC(MAX_CYC), .LOSS_CYC(LOSS_CYC)) u_meas (
    .clk(clk), .rst_n(rst_n), .lvl(lvl), .rise(rise_evt), .fall(fall_evt),
    .done(meas_done), .len(meas_len), .present(sig_present)
  );

  rcpw_scale #(.MIN_CYC(MIN_CYC), .MAX_CYC(MAX_CYC)) u_scale (
    .clk(clk), .rst_n(rst_n), .start(meas_done), .len(meas_len),
    .done(scale_done), .result(scale_res)
  );

  // One-word output holding register; a newer result overwrites.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_valid <= 1'b0;
      pos_data  <= '0;
    end else if (scale_done) begin
      pos_valid <= 1'b1;
      pos_data  <= scale_res;
    end else if (pos_valid && pos_ready) begin
      pos_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/rc_pulse_decoder_chk.sv
module rc_pulse_decoder_chk #(
  parameter int MIN_CYC  = 40000,
  parameter int MAX_CYC  = 110000,
  parameter int LOSS_CYC = 5000000,
  localparam int CW = $clog2(MAX_CYC + 2)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pos_valid,
  input logic          pos_ready,
  input logic [9:0]    pos_data,
  input logic          sig_present,
  input logic          rise_evt,
  input logic          meas_done,
  input logic [CW-1:0] meas_len,
  input logic          scale_done
);
  localparam int SW   = $clog2(LOSS_CYC + 3);
  localparam int LIM  = LOSS_CYC + 2;
  localparam int LIM1 = LOSS_CYC + 1;
  localparam logic [SW-1:0] LIM_T  = LIM[SW-1:0];
  localparam logic [SW-1:0] LIM1_T = LIM1[SW-1:0];

  logic [SW-1:0] since;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              since <= LIM_T;
    else if (rise_evt)       since <= '0;
    else if (since != LIM_T) since <= since + SW'(1);
  end

  // R4
  len_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    meas_done |-> (int'(meas_len) >= MIN_CYC && int'(meas_len) <= MAX_CYC));

  // R5
  hold_until_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_valid && !pos_ready && !scale_done) |=> (pos_valid && $stable(pos_data)));

  // R9
  drop_after_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_valid && pos_ready && !scale_done) |=> !pos_valid);

  // R9
  valid_from_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pos_valid) |-> $past(scale_done));

  // R7
  present_from_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sig_present) |-> $past(rise_evt));

  // R8
  present_times_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (since >= LIM1_T) |-> !sig_present);
endmodule

bind rc_pulse_decoder rc_pulse_decoder_chk #(
  .MIN_CYC(MIN_CYC), .MAX_CYC(MAX_CYC), .LOSS_CYC(LOSS_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .pos_valid(pos_valid), .pos_ready(pos_ready),
  .pos_data(pos_data), .sig_present(sig_present), .rise_evt(rise_evt),
  .meas_done(meas_done), .meas_len(meas_len), .scale_done(scale_done)
);

// File: tb/tb_rc_pulse_decoder.sv
`timescale 1ns/1ps
module tb_rc_pulse_decoder;
  localparam int MINC = 80;
  localparam int MAXC = 220;
  localparam int LOSS = 3000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rc_in = 1'b1;
  logic       pos_ready = 1'b1;
  logic [9:0] pos_data;
  logic       pos_valid;
  logic       sig_present;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;
  logic [9:0] expq[$];

  always #2.5 clk = ~clk;

  rc_pulse_decoder #(.MIN_CYC(MINC), .MAX_CYC(MAXC), .LOSS_CYC(LOSS)) dut (
    .clk(clk), .rst_n(rst_n), .rc_in(rc_in), .pos_data(pos_data),
    .pos_valid(pos_valid), .pos_ready(pos_ready), .sig_present(sig_present)
  );

  function automatic logic [9:0] model(int w);
    int c, q;
    c = (w < MINC) ? MINC : (w > MAXC) ? MAXC : w;          // R4
    q = ((c - MINC) * 1023 + (MAXC - MINC) / 2) / (MAXC - MINC); // R3
    return 10'(q - 512);
  endfunction

  task automatic tick(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse(int w, int gap, bit push);
    if (push) expq.push_back(model(w));
    rc_in = 1'b1; tick(w);
    rc_in = 1'b0; tick(gap);
  endtask

  // Scoreboard monitor: a transfer happens at the next edge.
  always @(negedge clk) begin
    if (rst_n && pos_valid && pos_ready) begin
      n_chk++;
      if (expq.size() == 0) begin
        n_bad++;
        $display("FAIL R9 actual=%0d expected=none (unexpected word)", $signed(pos_data));
      end else begin
        logic [9:0] e;
        e = expq.pop_front();
        if (pos_data !== e) begin
          n_bad++;
          $display("FAIL R3 actual=%0d expected=%0d", $signed(pos_data), $signed(e));
        end
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    tick(5);
    rst_n = 1'b1;
    tick(2);
    // R1
    check(pos_valid == 1'b0, "R1 valid", pos_valid, 0);
    check(sig_present == 1'b0, "R1 present", sig_present, 0);
    // R2: line high from reset, then falls; no word must appear
    tick(20);
    rc_in = 1'b0;
    tick(100);
    check(pos_valid == 1'b0, "R2 no word", pos_valid, 0);
    check(sig_present == 1'b0, "R2 present", sig_present, 0);

    // R3 / R4 sweep
    pulse(MINC, 150, 1);
    // R7
    check(sig_present == 1'b1, "R7 present", sig_present, 1);
    pulse(MAXC, 150, 1);
    pulse(150, 150, 1);
    pulse(100, 150, 1);
    pulse(200, 150, 1);
    pulse(81, 150, 1);
    pulse(219, 150, 1);
    pulse(30, 150, 1);   // R4 below window
    pulse(500, 150, 1);  // R4 above window
    pulse(1, 150, 1);    // R4 minimal pulse
    check(expq.size() == 0, "R9 drained", expq.size(), 0);

    // R5 / R6: back-pressure and overwrite
    pos_ready = 1'b0;
    pulse(120, 150, 0);
    check(pos_valid == 1'b1, "R5 held", pos_valid, 1);
    pulse(180, 150, 1);
    check(pos_valid == 1'b1, "R5 still held", pos_valid, 1);
    pos_ready = 1'b1;
    tick(1);
    tick(1);
    // R9
    check(pos_valid == 1'b0, "R9 drop", pos_valid, 0);
    check(expq.size() == 0, "R6 single word", expq.size(), 0);

    // R8: loss window
    pulse(150, 0, 1);
    tick(LOSS - 300);
    check(sig_present == 1'b1, "R8 inside window", sig_present, 1);
    tick(300);
    check(sig_present == 1'b0, "R8 timed out", sig_present, 0);
    pulse(160, 150, 1);
    // R7
    check(sig_present == 1'b1, "R7 regained", sig_present, 1);
    tick(50);
    check(expq.size() == 0, "R9 final drain", expq.size(), 0);
    finish_run();
  end
endmodule